// File: doc/BRIEF.md
# Toggle-Handshake Single-Port Word Memory

This block is a single-port synchronous word store driven by a small requester front end that takes one load or one store command at a time. The requester does not raise a level enable to ask for an access. It keeps a request word and flips every bit of it whenever it wants the memory to act. The memory keeps its own acknowledge word. Any difference between the two words means an access is waiting. On each falling clock edge the memory performs the waiting access and copies the request word into the acknowledge word, which closes the handshake.

The requester side runs on rising edges and the memory side runs on falling edges, so a command accepted on one rising edge is serviced half a cycle later. Its result is visible after the next rising edge. The memory acts only when an access is waiting and the address is below the configured depth. Any other address is silently skipped. The handshake words, address, write data and read data are all 32 bits wide.

Top module: `tgr_top`

## Requirements
- R1: While reset is held and after it is released, `cmd_ready` is 1, `done` is 0 and `rsp_rdata` is 0.
- R2: A store (`cmd_write`=1) of data D to an in-range address A, followed later by a load (`cmd_write`=0) from A, returns D on `rsp_rdata`. A later store to A replaces the word.
- R3: A store to an address greater than or equal to DEPTH changes no memory word. Addresses are compared over the full 32 bits, so there is no aliasing onto low addresses.
- R4: A load from an address greater than or equal to DEPTH reads no word. `rsp_rdata` then shows the word returned by the most recent in-range load.
- R5: A command accepted on rising edge N raises `done` after edge N+1 for exactly one cycle. For a load, `rsp_rdata` holds the loaded word in that same cycle.
- R6: After an accepting edge, `cmd_ready` is 0 until `done` rises. The request word changes only on an accepting edge. Each accepted command produces exactly one `done`, and back-to-back commands each perform exactly one access.
- R7: A command presented while `cmd_ready` is 0 is ignored: it writes nothing and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The requester uses the rising edge and the memory uses the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block. |
| cmd_valid | input | 1 | A command is presented. |
| cmd_write | input | 1 | 1 = store, 0 = load. |
| cmd_addr | input | 32 | Word address. |
| cmd_wdata | input | 32 | Store data. |
| cmd_ready | output | 1 | The block is idle and accepts a command on this edge. |
| done | output | 1 | One-cycle completion pulse. |
| rsp_rdata | output | 32 | Result of the most recent load. |

## Verification
The hardest case to provoke is a command that arrives while the handshake is still open. `cmd_ready` is low for only the single cycle after acceptance, so a normal driver that waits for `cmd_ready` never presents a command then. The stimulus therefore drives a second store directly into that busy cycle and withdraws it one edge later. The bench then reads the targeted word to confirm it is unchanged and counts `done` pulses to confirm the ignored store was never serviced. Out-of-range loads are placed straight after a known in-range load, so the stale read-data word they must return is predictable.

// File: rtl/tgr_pkg.sv
package tgr_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/tgr_rst_sync.sv
module tgr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tgr_requester.sv
module tgr_requester
  import tgr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int HS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [HS_W-1:0]   ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [HS_W-1:0]   req_tgl,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_we,
  output logic [DATA_W-1:0] req_wdata,
  output logic              busy
);
  logic [HS_W-1:0]   tgl_q, tgl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] res_q, res_d;
  op_e               op_q, op_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              accept;

  assign cmd_ready = !busy_q && (tgl_q == ack);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    tgl_d   = tgl_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    op_d    = op_q;
    res_d   = res_q;
    busy_d  = accept;
    done_d  = busy_q;
    if (accept) begin
      tgl_d   = ~tgl_q;
      addr_d  = cmd_addr;
      wdata_d = cmd_wdata;
      op_d    = cmd_write ? OP_STORE : OP_LOAD;
    end
    if (busy_q && op_q == OP_LOAD) res_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      op_q    <= OP_LOAD;
      res_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      tgl_q   <= tgl_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      op_q    <= op_d;
      res_q   <= res_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign req_tgl   = tgl_q;
  assign req_addr  = addr_q;
  assign req_we    = {{(DATA_W-1){1'b0}}, (op_q == OP_STORE)};
  assign req_wdata = wdata_q;
  assign done      = done_q;
  assign rsp_rdata = res_q;
  assign busy      = busy_q;
endmodule

// File: rtl/tgr_mem.sv
module tgr_mem #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int HS_W   = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HS_W-1:0]   req_tgl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [HS_W-1:0]   ack,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [HS_W-1:0]   ack_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              pending, in_range, do_wr, do_rd;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    pending  = (ack_q != req_tgl);
    in_range = (req_addr < LIMIT);
    do_wr    = pending && in_range && (req_we != '0);
    do_rd    = pending && in_range && (req_we == '0);
    idx      = req_addr[IDX_W-1:0];
    rdata_d  = do_rd ? store_q[idx] : rdata_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= '0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_tgl;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(negedge clk) begin
    if (do_wr) store_q[idx] <= req_wdata;
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/tgr_top.sv
module tgr_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int HS_W = 32;

  logic              rst_sync_n;
  logic [HS_W-1:0]   req_tgl, mem_ack;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_we, req_wdata, mem_rdata;
  logic              req_busy;

  tgr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  tgr_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HS_W(HS_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_valid(cmd_valid),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready),
    .done     (done),
    .rsp_rdata(rsp_rdata),
    .ack      (mem_ack),
    .mem_rdata(mem_rdata),
    .req_tgl  (req_tgl),
    .req_addr (req_addr),
    .req_we   (req_we),
    .req_wdata(req_wdata),
    .busy     (req_busy)
  );

  tgr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HS_W(HS_W), .DEPTH(DEPTH)) u_mem (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_tgl  (req_tgl),
    .req_addr (req_addr),
    .req_we   (req_we),
    .req_wdata(req_wdata),
    .ack      (mem_ack),
    .rdata    (mem_rdata)
  );
endmodule

// File: rtl/tgr_checker.sv
module tgr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        done,
  input logic        busy,
  input logic [31:0] tgl,
  input logic [31:0] ack
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R5

  AST_READY_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R6

  AST_TOGGLE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl != $past(tgl)) |-> $past(cmd_valid && cmd_ready)); // R6

  AST_ACK_CAUGHT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ack == tgl)); // R6

  AST_IGNORED_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(tgl)); // R7
endmodule

bind tgr_top tgr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .done     (done),
  .busy     (req_busy),
  .tgl      (req_tgl),
  .ack      (mem_ack)
);

// File: tb/tgr_top_bench.sv
`timescale 1ns/1ps
module tgr_top_bench;
  localparam int DEPTH  = 16;
  localparam int MAX_CY = 200000;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_write;
  logic [31:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic        cmd_ready;
  logic        done;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  int done_seen = 0;
  int issued = 0;
  bit finished = 0;

  logic [31:0] ref_mem [DEPTH];
  logic [31:0] last_rd;

  typedef struct {
    bit          is_load;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  tgr_top #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) u_tgr_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .done(done), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    #1;
    if (rst_n && done) begin
      done_seen++;
      if (sb_q.size() == 0) begin
        check(0, "R6 unexpected done", 32'h1, 32'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.is_load) check(rsp_rdata == it.exp, it.tag, rsp_rdata, it.exp);
      end
    end
  end

  task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d, input string tag);
    item_t it;
    @(posedge clk); #1;
    while (!cmd_ready) begin @(posedge clk); #1; end
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    it.is_load = !wr;
    it.tag = tag;
    if (wr) begin
      if (a < DEPTH) ref_mem[a] = d;
      it.exp = '0;
    end else begin
      if (a < DEPTH) last_rd = ref_mem[a];
      it.exp = last_rd;
    end
    sb_q.push_back(it);
    issued++;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R6 ready low after accept", {31'b0, cmd_ready}, 32'h0);
    check(done == 1'b0, "R5 done not early", {31'b0, done}, 32'h0);
    @(posedge clk); #1;
    check(done == 1'b1, "R5 done one edge after access", {31'b0, done}, 32'h1);
    @(posedge clk); #1;
    check(done == 1'b0, "R5 done single cycle", {31'b0, done}, 32'h0);
  endtask

  initial begin
    repeat (MAX_CY) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0;
    last_rd = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check(cmd_ready == 1'b1, "R1 ready in reset", {31'b0, cmd_ready}, 32'h1);
    check(done == 1'b0, "R1 done in reset", {31'b0, done}, 32'h0);
    check(rsp_rdata == '0, "R1 rdata in reset", rsp_rdata, 32'h0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check(cmd_ready == 1'b1 && done == 1'b0 && rsp_rdata == '0, "R1 state after release",
          {cmd_ready, done, rsp_rdata[29:0]}, 32'h8000_0000);

    // R2: fill every word then read each back
    for (int i = 0; i < DEPTH; i++) issue(1, i, 32'hA500_0000 + i * 32'h0101, "R2 fill");
    for (int i = 0; i < DEPTH; i++) issue(0, i, '0, "R2 readback");
    // R2: overwrite then read
    issue(1, 3, 32'hDEAD_BEEF, "R2 overwrite");
    issue(0, 3, '0, "R2 overwrite readback");
    issue(1, 3, 32'h1234_5678, "R2 second overwrite");
    issue(0, 3, '0, "R2 second readback");

    // R3: out-of-range stores, no aliasing
    issue(1, DEPTH, 32'hBAD0_0001, "R3 store at depth");
    issue(1, DEPTH + 3, 32'hBAD0_0002, "R3 store above depth");
    issue(1, 32'hFFFF_FFF0, 32'hBAD0_0003, "R3 store high alias");
    issue(0, 0, '0, "R3 word0 unchanged");
    issue(0, 3, '0, "R3 word3 unchanged");

    // R4: out-of-range load returns last read word
    issue(0, 5, '0, "R4 prime read");
    issue(0, 32'd100, '0, "R4 oor load keeps last word");
    issue(0, DEPTH, '0, "R4 load at depth");

    // R7: command presented in the busy cycle is ignored
    begin
      item_t it;
      @(posedge clk); #1;
      while (!cmd_ready) begin @(posedge clk); #1; end
      cmd_valid = 1; cmd_write = 1; cmd_addr = 7; cmd_wdata = 32'h7777_0007;
      ref_mem[7] = 32'h7777_0007;
      it.is_load = 0; it.exp = '0; it.tag = "R7 first store";
      sb_q.push_back(it);
      issued++;
      @(posedge clk); #1;
      cmd_addr = 8; cmd_wdata = 32'hEEEE_0008;
      @(posedge clk); #1;
      cmd_valid = 0;
      repeat (2) @(posedge clk);
    end
    issue(0, 8, '0, "R7 ignored store left word8");
    issue(0, 7, '0, "R7 accepted store landed");

    repeat (4) @(posedge clk);
    #1;
    check(done_seen == issued, "R6 one done per command", done_seen, issued);
    check(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 32'h0);
    finish_run();
  end
endmodule